// File: doc/BRIEF.md
# Serial Receive Channel with Error Detection and Wake-up Filtering

This block turns an asynchronous serial line into a stream of characters held for a host. A baud enable pulses sixteen times per bit. On each of those pulses the receiver looks at the line, which must already be synchronised to `clk`. It finds start bits, throws away glitches and samples each bit in the middle. It builds characters of 5 to 8 bits, least significant bit first. It then checks the optional parity slot and the stop bit. Each finished character goes, with its status flags, into a first-word-fall-through queue that holds 16 characters. The host reads the queue one entry at a time.

The same front end also finds line breaks, including a break that begins partway through a character, and it signals the start and the end of each break. In multi-drop mode the parity slot carries an address/data marker. While the channel is asleep, data characters are dropped. An address character wakes it. An idle timer flags characters that have waited in the queue too long with nothing new arriving. All configuration inputs are static while a character is being received.

Top module: `serial_rx_channel`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty (`rx_count` 0, `rx_empty` 1), and `rx_overrun`, `rx_awake`, `rx_timeout`, `brk_start` and `brk_end` are all 0.
- R2: A start is detected on the first baud tick that sees the line low. The start bit is confirmed on the 8th tick after that, and each later bit is sampled every 16 ticks. Data arrives LSB first. `cfg_len` 0/1/2/3 selects 5/6/7/8 data bits, and unused upper bits of `rd_data` read 0.
- R3: If the line is high again at the start-bit confirmation sample, the receiver returns to idle and stores nothing.
- R4: `cfg_par` selects the parity slot: 00 none, 01 even (the data ones plus the parity bit give an even total), 10 odd, 11 forced, where the bit must equal `cfg_par_val`. A mismatch sets `rd_perr` for that character.
- R5: A stop bit sampled low on a character that is not all-low stores the character with `rd_frm` set.
- R6: A frame in which start, data, parity slot and stop are all low stores a single character with data 0 and `rd_brk` set, with the other flags clear. `brk_start` pulses for one cycle in the same cycle that the character becomes pending. No further start is looked for until the line is high again, and `brk_end` then pulses for one cycle. A break that begins in the middle of a character first yields that character with `rd_frm` set, then the break character.
- R7: The queue holds 16 entries in arrival order. The head is visible on the read outputs, and `rd_en` removes it when the queue is not empty.
- R8: A character that arrives while the queue is full is dropped, even if a read happens in the same cycle. The stored entries are kept, and `rx_overrun` is set. It stays set until `ovr_clr`; if a new overrun and the clear happen in the same cycle, the flag stays set.
- R9: With `cfg_multidrop` set, the parity slot is stored as `rd_addr` (1 = address) and no parity error is raised. While `rx_awake` is 0, only characters with the address flag are stored. Such a character sets `rx_awake`, and `sleep_req` clears it.
- R10: `rx_timeout` is 1 when `cfg_idle_limit` is non-zero, the queue is not empty, and `cfg_idle_limit` baud ticks have passed since the last stored character or since the queue last became non-empty. It drops when a character is stored or the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | Baud enable, 16 pulses per bit |
| rx_line | input | 1 | Synchronised serial input, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 forced |
| cfg_par_val | input | 1 | Required parity bit in forced mode |
| cfg_multidrop | input | 1 | Parity slot carries the address flag |
| cfg_idle_limit | input | TO_W | Idle time-out in baud ticks, 0 disables it |
| rd_en | input | 1 | Remove the head entry |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| sleep_req | input | 1 | Return to the asleep state in multi-drop mode |
| rd_data | output | 8 | Head character |
| rd_brk | output | 1 | Head entry is a break |
| rd_addr | output | 1 | Head entry carried the address flag |
| rd_frm | output | 1 | Head entry had a framing error |
| rd_perr | output | 1 | Head entry had a parity error |
| rx_empty | output | 1 | Queue empty |
| rx_count | output | $clog2(FIFO_DEPTH+1) | Entries held |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_awake | output | 1 | Multi-drop wake state |
| rx_timeout | output | 1 | Idle time-out flag |
| brk_start | output | 1 | One-cycle pulse at break detection |
| brk_end | output | 1 | One-cycle pulse when the line returns high after a break |

## Verification
The hardest case to reach from the ports is a break that begins inside a character. The bench drives it by sending a start bit and three ones, then holding the line low for many character times. This forces the framing-error character and the break character to be queued one after the other, with a single pair of break events. A behavioural model in the bench steps through the same tick schedule and is compared with every output on every clock. This covers the glitch start, the overrun with a full queue, and the asleep/awake filtering in multi-drop mode.

// File: rtl/rxu_pkg.sv
// Shared definitions for the serial receive channel.
// Assumes a fixed 16x oversampling ratio and an 8-bit data field.
package rxu_pkg;

    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);
    localparam int DATA_W = 8;

    localparam logic [1:0] PAR_NONE  = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ODD   = 2'b10;
    localparam logic [1:0] PAR_FORCE = 2'b11;

    typedef enum logic [2:0] {
        FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP, FS_BRKW
    } rxu_fstate_t;

    typedef struct packed {
        logic              brk;
        logic              addr;
        logic              frm;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rxu_char_t;

endpackage

// File: rtl/rxu_framer.sv
// Bit-level receive state machine.
// Looks for a start bit, confirms it at mid-bit, then samples the data,
// parity and stop bits every OVS ticks. It emits one registered character
// per frame, with its flags, and the break start/end pulses.
// Assumes rx is synchronous to clk and the configuration is static during a frame.
module rxu_framer
    import rxu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_par_val,
    input  logic       cfg_multidrop,
    output logic       chr_valid,
    output rxu_char_t  chr,
    output logic       brk_start,
    output logic       brk_end
);

    localparam logic [OVS_W-1:0] SMP_MID = OVS_W'(OVS/2 - 1);
    localparam logic [OVS_W-1:0] SMP_END = OVS_W'(OVS - 1);

    rxu_fstate_t       state;
    logic [OVS_W-1:0]  cnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shreg;
    logic              parbit;
    logic [2:0]        last_idx;
    logic              has_par;
    logic              perr_c;
    logic              all_low;

    assign last_idx = 3'(cfg_len) + 3'd4;
    assign has_par  = (cfg_par != PAR_NONE) || cfg_multidrop;
    assign all_low  = (shreg == '0) && (!has_par || !parbit) && !rx;

    // Parity check of the completed data field against the selected mode.
    always_comb begin
        perr_c = 1'b0;
        if (!cfg_multidrop) begin
            unique case (cfg_par)
                PAR_EVEN:  perr_c = ^shreg ^ parbit;
                PAR_ODD:   perr_c = ~(^shreg ^ parbit);
                PAR_FORCE: perr_c = (parbit != cfg_par_val);
                default:   perr_c = 1'b0;
            endcase
        end
    end

    // Frame sequencing, bit sampling and character/break output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            parbit    <= 1'b0;
            chr_valid <= 1'b0;
            chr       <= '0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            chr_valid <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (tick) begin
                unique case (state)
                    FS_IDLE: begin
                        if (!rx) begin
                            state <= FS_START;
                            cnt   <= '0;
                        end
                    end
                    FS_START: begin
                        if (cnt == SMP_MID) begin
                            cnt <= '0;
                            if (rx) begin
                                state <= FS_IDLE;
                            end else begin
                                state <= FS_DATA;
                                bidx  <= '0;
                                shreg <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (cnt == SMP_END) begin
                            cnt         <= '0;
                            shreg[bidx] <= rx;
                            if (bidx == last_idx) begin
                                state <= has_par ? FS_PAR : FS_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_PAR: begin
                        if (cnt == SMP_END) begin
                            cnt    <= '0;
                            parbit <= rx;
                            state  <= FS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_STOP: begin
                        if (cnt == SMP_END) begin
                            cnt       <= '0;
                            chr_valid <= 1'b1;
                            if (all_low) begin
                                chr       <= '{brk: 1'b1, addr: 1'b0, frm: 1'b0,
                                               perr: 1'b0, data: '0};
                                brk_start <= 1'b1;
                                state     <= FS_BRKW;
                            end else begin
                                chr.brk  <= 1'b0;
                                chr.addr <= cfg_multidrop & parbit;
                                chr.frm  <= !rx;
                                chr.perr <= perr_c;
                                chr.data <= shreg;
                                state    <= FS_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_BRKW: begin
                        if (rx) begin
                            brk_end <= 1'b1;
                            state   <= FS_IDLE;
                        end
                    end
                    default: state <= FS_IDLE;
                endcase
            end
        end
    end

    assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_START && tick && cnt == SMP_MID && rx) |=> (state == FS_IDLE && !chr_valid));

    assert_single_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |=> !chr_valid);

    assert_brk_with_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |-> (chr_valid && chr.brk && chr.data == '0));

    assert_brk_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !brk_start);

endmodule

// File: rtl/rxu_fifo.sv
// First-word-fall-through character queue.
// The head entry is always visible on rd_data. A write while full is refused
// by the caller, and a read while empty is ignored.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module rxu_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             do_wr;
    logic             do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

endmodule

// File: rtl/rxu_idle_timer.sv
// Receive idle watchdog.
// Counts baud ticks while the queue holds data and nothing new is stored,
// and flags when the programmed limit is reached. A limit of zero disables it.
module rxu_idle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          push,
    input  logic          empty,
    input  logic [TW-1:0] limit,
    output logic          flag
);

    logic [TW-1:0] cnt;

    // Tick counter, restarted by each stored character or an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push || empty) begin
            cnt <= '0;
        end else if (tick && cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign flag = (limit != '0) && !empty && (cnt >= limit);

    assert_timeout_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !flag);

endmodule

// File: rtl/serial_rx_channel.sv
// Top of the serial receive channel.
// Connects the framer to the character queue. It also applies the multi-drop
// wake filter, keeps the sticky overrun flag and drives the idle time-out.
// Assumes tick_16x is a one-cycle enable and rx_line is already synchronised.
module serial_rx_channel
    import rxu_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_W       = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_16x,
    input  logic                            rx_line,
    input  logic [1:0]                      cfg_len,
    input  logic [1:0]                      cfg_par,
    input  logic                            cfg_par_val,
    input  logic                            cfg_multidrop,
    input  logic [TO_W-1:0]                 cfg_idle_limit,
    input  logic                            rd_en,
    input  logic                            ovr_clr,
    input  logic                            sleep_req,
    output logic [7:0]                      rd_data,
    output logic                            rd_brk,
    output logic                            rd_addr,
    output logic                            rd_frm,
    output logic                            rd_perr,
    output logic                            rx_empty,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count,
    output logic                            rx_overrun,
    output logic                            rx_awake,
    output logic                            rx_timeout,
    output logic                            brk_start,
    output logic                            brk_end
);

    localparam int CHR_W = $bits(rxu_char_t);

    logic             chr_valid;
    rxu_char_t        chr;
    logic             accept;
    logic             fifo_wr;
    logic             fifo_full;
    logic [CHR_W-1:0] head_bits;
    rxu_char_t        head;

    rxu_framer u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick_16x),
        .rx            (rx_line),
        .cfg_len       (cfg_len),
        .cfg_par       (cfg_par),
        .cfg_par_val   (cfg_par_val),
        .cfg_multidrop (cfg_multidrop),
        .chr_valid     (chr_valid),
        .chr           (chr),
        .brk_start     (brk_start),
        .brk_end       (brk_end)
    );

    // A character is wanted unless multi-drop sleep filters it out.
    assign accept  = chr_valid && (!cfg_multidrop || rx_awake || chr.addr);
    assign fifo_wr = accept && !fifo_full;

    rxu_fifo #(
        .WIDTH (CHR_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (chr),
        .rd_en   (rd_en),
        .rd_data (head_bits),
        .empty   (rx_empty),
        .full    (fifo_full),
        .count   (rx_count)
    );

    assign head    = rxu_char_t'(head_bits);
    assign rd_data = head.data;
    assign rd_brk  = head.brk;
    assign rd_addr = head.addr;
    assign rd_frm  = head.frm;
    assign rd_perr = head.perr;

    // Sticky overrun: set by a wanted character meeting a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rx_overrun <= 1'b0;
        else if (accept && fifo_full) rx_overrun <= 1'b1;
        else if (ovr_clr)             rx_overrun <= 1'b0;
    end

    // Multi-drop wake state: an address character wakes, sleep_req sleeps.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rx_awake <= 1'b0;
        else if (accept && cfg_multidrop && chr.addr) rx_awake <= 1'b1;
        else if (sleep_req)                         rx_awake <= 1'b0;
    end

    rxu_idle_timer #(
        .TW (TO_W)
    ) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_16x),
        .push  (fifo_wr),
        .empty (rx_empty),
        .limit (cfg_idle_limit),
        .flag  (rx_timeout)
    );

    assert_sleep_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && cfg_multidrop && !rx_awake && !chr.addr) |-> !fifo_wr);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

    assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fifo_full && !rd_en) |=> (rx_count == $past(rx_count)));

endmodule

// File: tb/serial_rx_channel_test.sv
// Bench: drives serial frames and compares every output on every clock with
// a behavioural model (tick schedule, queue of expected entries).
module serial_rx_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_16x = 1'b0;
    logic        rx_line = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_par = 2'b00;
    logic        cfg_par_val = 1'b0;
    logic        cfg_multidrop = 1'b0;
    logic [15:0] cfg_idle_limit = 16'd250;
    logic        rd_en = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        sleep_req = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_brk, rd_addr, rd_frm, rd_perr;
    logic        rx_empty;
    logic [4:0]  rx_count;
    logic        rx_overrun, rx_awake, rx_timeout, brk_start, brk_end;

    serial_rx_channel uut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_val(cfg_par_val),
        .cfg_multidrop(cfg_multidrop), .cfg_idle_limit(cfg_idle_limit),
        .rd_en(rd_en), .ovr_clr(ovr_clr), .sleep_req(sleep_req),
        .rd_data(rd_data), .rd_brk(rd_brk), .rd_addr(rd_addr), .rd_frm(rd_frm),
        .rd_perr(rd_perr), .rx_empty(rx_empty), .rx_count(rx_count),
        .rx_overrun(rx_overrun), .rx_awake(rx_awake), .rx_timeout(rx_timeout),
        .brk_start(brk_start), .brk_end(brk_end)
    );

    always #2 clk = ~clk;

    int n_vec = 0;
    int n_fail = 0;
    int n_bs = 0;
    int n_be = 0;
    bit done = 0;

    // Baud enable: one cycle in four.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick_16x = (tdiv == 0);
    end

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [11:0] q[$];
    int  ms = 0, mc = 0, mb = 0;
    bit [7:0] md;
    bit  mp, pv, e_bs, e_be, m_ovr, m_awake;
    bit [11:0] pch;
    int  m_to = 0;

    always @(posedge clk) begin
        int  pre;
        bit  acc, wr, hp, pe;
        if (!rst_n) begin
            q.delete();
            ms = 0; mc = 0; mb = 0; md = 0; mp = 0; pv = 0; pch = 0;
            e_bs = 0; e_be = 0; m_ovr = 0; m_awake = 0; m_to = 0;
        end else begin
            pre = q.size();
            acc = pv && (!cfg_multidrop || m_awake || pch[10]);
            wr  = acc && pre < 16;
            if (rd_en && pre > 0) void'(q.pop_front());
            if (wr) q.push_back(pch);
            if (acc && pre == 16) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
            if (acc && cfg_multidrop && pch[10]) m_awake = 1; else if (sleep_req) m_awake = 0;
            if (wr || pre == 0) m_to = 0;
            else if (tick_16x && m_to < int'(cfg_idle_limit)) m_to++;
            pv = 0; e_bs = 0; e_be = 0;
            hp = (cfg_par != 2'b00) || cfg_multidrop;
            if (tick_16x) begin
                case (ms)
                    0: if (!rx_line) begin ms = 1; mc = 0; end
                    1: if (mc == 7) begin
                           mc = 0;
                           if (rx_line) ms = 0; else begin ms = 2; mb = 0; md = 0; end
                       end else mc++;
                    2: if (mc == 15) begin
                           md[mb] = rx_line; mc = 0;
                           if (mb == int'(cfg_len) + 4) ms = hp ? 3 : 4; else mb++;
                       end else mc++;
                    3: if (mc == 15) begin mp = rx_line; mc = 0; ms = 4; end else mc++;
                    4: if (mc == 15) begin
                           mc = 0; pv = 1;
                           if (!rx_line && md == 0 && (!hp || !mp)) begin
                               pch = 12'h800; e_bs = 1; ms = 5;
                           end else begin
                               if (cfg_multidrop) pe = 0;
                               else case (cfg_par)
                                   2'b01: pe = ^md ^ mp;
                                   2'b10: pe = !(^md ^ mp);
                                   2'b11: pe = (mp != cfg_par_val);
                                   default: pe = 0;
                               endcase
                               pch = {1'b0, cfg_multidrop & mp, !rx_line, pe, md};
                               ms = 0;
                           end
                       end else mc++;
                    default: if (rx_line) begin e_be = 1; ms = 0; end
                endcase
            end
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7", "count", rx_count, q.size());
            chk("R7", "empty", rx_empty, q.size() == 0);
            chk("R8", "overrun", rx_overrun, m_ovr);
            chk("R9", "awake", rx_awake, m_awake);
            chk("R10", "timeout", rx_timeout,
                (cfg_idle_limit != 0) && q.size() > 0 && m_to >= int'(cfg_idle_limit));
            chk("R6", "brk_start", brk_start, e_bs);
            chk("R6", "brk_end", brk_end, e_be);
            if (q.size() > 0) begin
                chk("R2", "data", rd_data, q[0][7:0]);
                chk("R4", "perr", rd_perr, q[0][8]);
                chk("R5", "frm", rd_frm, q[0][9]);
                chk("R9", "addr", rd_addr, q[0][10]);
                chk("R6", "brk", rd_brk, q[0][11]);
            end
            if (brk_start) n_bs++;
            if (brk_end) n_be++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bit_time(bit v);
        rx_line = v;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(bit [7:0] d, int n, bit hasp, bit pbit, bit stopv);
        bit_time(1'b0);
        for (int i = 0; i < n; i++) bit_time(d[i]);
        if (hasp) bit_time(pbit);
        bit_time(stopv);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (!rx_empty) pop();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int bs0, be0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset count", rx_count, 0);
        chk("R1", "reset empty", rx_empty, 1);
        chk("R1", "reset flags", {rx_overrun, rx_awake, rx_timeout, brk_start, brk_end}, 0);

        // R2: 8 data bits, no parity
        repeat (30) @(negedge clk);
        send_frame(8'hA5, 8, 0, 0, 1);
        chk("R2", "8-bit char", rd_data, 8'hA5);
        chk("R5", "clean stop", rd_frm, 0);
        // R10: idle time-out after 250 ticks with nothing new
        repeat (1100) @(negedge clk);
        chk("R10", "timeout raised", rx_timeout, 1);
        pop();
        chk("R10", "timeout cleared by empty", rx_timeout, 0);

        // R4: 5-bit parity modes
        cfg_len = 2'd0; cfg_par = 2'b01;
        send_frame(8'h13, 5, 1, 1, 1);
        chk("R4", "even ok", rd_perr, 0);
        chk("R2", "5-bit data", rd_data, 8'h13);
        pop();
        send_frame(8'h13, 5, 1, 0, 1);
        chk("R4", "even bad", rd_perr, 1);
        pop();
        cfg_par = 2'b10;
        send_frame(8'h13, 5, 1, 0, 1);
        chk("R4", "odd ok", rd_perr, 0);
        pop();
        cfg_par = 2'b11; cfg_par_val = 1'b1;
        send_frame(8'h0A, 5, 1, 0, 1);
        chk("R4", "forced bad", rd_perr, 1);
        pop();
        send_frame(8'h0A, 5, 1, 1, 1);
        chk("R4", "forced ok", rd_perr, 0);
        pop();

        // R2: 6-bit; R5: 7-bit with framing error
        cfg_par = 2'b00; cfg_len = 2'd1;
        send_frame(8'h2A, 6, 0, 0, 1);
        chk("R2", "6-bit data", rd_data, 8'h2A);
        pop();
        cfg_len = 2'd2;
        send_frame(8'h41, 7, 0, 0, 0);
        repeat (200) @(negedge clk);
        chk("R5", "framing flag", rd_frm, 1);
        chk("R5", "framing data", rd_data, 8'h41);
        drain();

        // R3: short glitch is not a start
        cfg_len = 2'd3;
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3", "false start stores nothing", rx_count, 0);

        // R6: aligned break
        bs0 = n_bs; be0 = n_be;
        rx_line = 1'b0;
        repeat (64 * 25) @(negedge clk);
        chk("R6", "one break char", rx_count, 1);
        chk("R6", "break flag", rd_brk, 1);
        chk("R6", "no end while low", n_be - be0, 0);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R6", "break start pulses", n_bs - bs0, 1);
        chk("R6", "break end pulses", n_be - be0, 1);
        drain();

        // R6: break starting mid-character
        bs0 = n_bs;
        bit_time(1'b0);
        bit_time(1'b1); bit_time(1'b1); bit_time(1'b1);
        rx_line = 1'b0;
        repeat (64 * 25) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R6", "mid-char entries", rx_count, 2);
        chk("R6", "mid-char partial frm", rd_frm, 1);
        chk("R6", "mid-char partial data", rd_data, 8'h07);
        pop();
        chk("R6", "mid-char break flag", rd_brk, 1);
        chk("R6", "mid-char one start", n_bs - bs0, 1);
        drain();

        // R7/R8: fill and overflow
        for (int i = 0; i < 17; i++) send_frame(8'(8'h30 + i), 8, 0, 0, 1);
        chk("R7", "full count", rx_count, 16);
        chk("R8", "overrun set", rx_overrun, 1);
        chk("R8", "oldest kept", rd_data, 8'h30);
        for (int i = 0; i < 15; i++) pop();
        chk("R7", "order kept, last stored", rd_data, 8'h3F);
        pop();
        chk("R8", "overrun sticky", rx_overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk("R8", "overrun cleared", rx_overrun, 0);

        // R9: multi-drop wake-up
        cfg_multidrop = 1'b1;
        send_frame(8'h55, 8, 1, 0, 1);
        chk("R9", "data ignored asleep", rx_count, 0);
        send_frame(8'h12, 8, 1, 1, 1);
        chk("R9", "address stored", rx_count, 1);
        chk("R9", "address flag", rd_addr, 1);
        chk("R9", "woken", rx_awake, 1);
        send_frame(8'h34, 8, 1, 0, 1);
        chk("R9", "data stored awake", rx_count, 2);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        @(negedge clk);
        chk("R9", "asleep again", rx_awake, 0);
        send_frame(8'h77, 8, 1, 0, 1);
        chk("R9", "data ignored again", rx_count, 2);
        drain();
        repeat (50) @(negedge clk);
        finish_run();
    end

endmodule